// File: doc/BRIEF.md
# Cell-Balancing Switch Timing Sequencer

This block produces the gate-enable pattern for a converter that balances a stack of series capacitor cells. It moves charge from a source cell to a sink cell through a plain two-winding transformer. A bank of switch pairs connects any one cell to the transformer. Pair k joins node k of the stack, so cell c sits between pairs c and c+1. Four independent selector switches pick which winding, and which polarity, faces that cell.

While `enable` is high and the request is legal, the block repeats a switching period of programmable length. Each period runs these phases in order:

- **Magnetise:** the source cell's two pairs and one selector leg are on.
- **Dead time:** every switch is off.
- **Demagnetise, then non-conduction:** the sink cell's two pairs and a second selector leg are on.
- **End guard:** every switch is off before the next period starts.

A four-entry table picks the two selector legs. Its address is the odd/even parity of the source and sink indices. Illegal requests are refused and flagged. Dropping `enable` or pulsing `abort` stops the sequence on the next clock.

Top module: `bal_switch_seq`

## Requirements
- R1: While reset is held, every `muxEn` and `selEn` bit is low, `phase` is 0 (idle) and `reqErr` is low.
- R2: A legal request is sampled at a rising edge while idle with `enable` high and `abort` low. From the next cycle, for `magCnt` cycles, `phase` is 1 and `muxEn` has only bits src-1 and src set (pairs src and src+1). In the same cycles `selEn` has only the bit given by the magnetise leg code.
- R3: For the next `deadCnt` cycles, `phase` is 2 and all `muxEn` and `selEn` bits are low.
- R4: Next, `phase` is 3 for `demagCnt` cycles and then 4 until the end guard. Throughout, `muxEn` has only bits snk-1 and snk set, and `selEn` has only the bit given by the demagnetise leg code.
- R5: The last `guardCnt` cycles of each `periodCnt`-cycle period have `phase` 5 with all outputs low. The next period then begins with the magnetise phase.
- R6: The selector table has 4 entries. The address is {source index even, sink index even}, so bit 1 is 1 when the source is even. Each entry is {demagnetise leg[3:2], magnetise leg[1:0]}. Leg codes are 0=1a, 1=1b, 2=2a and 3=2b, and code c lights `selEn[c]`. A write takes effect at the clock edge. Reset loads every entry with magnetise 1a and demagnetise 2b (4'b1100).
- R7: An index outside 1..NUM_CELLS, or a source equal to the sink, raises `reqErr` in the cycle after it is sampled with `enable` high, and all outputs stay low.
- R8: Any zero among `magCnt`, `deadCnt`, `demagCnt` and `guardCnt` raises `reqErr` with outputs low. So does a sum of those four counts that exceeds `periodCnt`. A sum equal to `periodCnt` is legal and leaves the non-conduction phase empty.
- R9: `enable` low or `abort` high at an edge makes `phase` 0 and all outputs low from the next cycle.
- R10: At most one `selEn` bit and either zero or two `muxEn` bits are ever high.
- R11: Indices and counts are captured at start. Changing them during a run has no effect on the outputs until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low stops the sequence |
| abort | input | 1 | Synchronous stop |
| srcIdx | input | IDX_W | Source cell index, 1..NUM_CELLS |
| snkIdx | input | IDX_W | Sink cell index, 1..NUM_CELLS |
| periodCnt | input | CNT_W | Switching period in clock cycles |
| magCnt | input | CNT_W | Magnetise length in cycles |
| deadCnt | input | CNT_W | Dead-time length in cycles |
| demagCnt | input | CNT_W | Demagnetise window in cycles |
| guardCnt | input | CNT_W | End-of-period all-off guard in cycles |
| selWrEn | input | 1 | Selector table write strobe |
| selWrAddr | input | 2 | Selector table entry (parity pair) |
| selWrData | input | 4 | Entry value {demag leg, mag leg} |
| muxEn | output | NUM_CELLS+1 | Switch-pair enables; bit k-1 drives pair k |
| selEn | output | 4 | Selector enables: 1a, 1b, 2a, 2b |
| phase | output | 3 | 0 idle, 1 mag, 2 dead, 3 demag, 4 non-conduct, 5 guard |
| reqErr | output | 1 | Request refused |

## Verification
The bench tries every source and sink index in the 3-bit space. That separates legal pairs from out-of-range indices and from the source-equal-sink case. It also covers all four parity combinations, so each table entry is exercised.

The sweep runs once with the reset table and a period that leaves a non-conduction gap. It runs again with a distinct leg code written in each entry and a period filled exactly. A mismatch in the second run therefore points at table addressing or at phase boundaries rather than at pair decoding.

Separate runs cover a timing set that overshoots by one cycle, a zero count, an abort in the middle of a period, and input changes in the middle of a run that must be ignored.

// File: rtl/bal_switch_seq_pkg.sv
package bal_switch_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_MAG     = 3'd1,
    PH_DEAD    = 3'd2,
    PH_DEMAG   = 3'd3,
    PH_NONCOND = 3'd4,
    PH_GUARD   = 3'd5
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   latchReq;  // capture indices this edge
    phase_e phase;     // current phase of the period
  } ctrl_strobe_t;

  localparam int LEG_W   = 2;
  localparam int ENTRY_W = 2 * LEG_W;
  localparam int TBL_N   = 4;
  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 4'b1100; // mag 1a, demag 2b

endpackage

// File: rtl/bal_ctrl.sv
module bal_ctrl
  import bal_switch_seq_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             abort,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] snkIdx,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [CNT_W-1:0] magCnt,
  input  logic [CNT_W-1:0] deadCnt,
  input  logic [CNT_W-1:0] demagCnt,
  input  logic [CNT_W-1:0] guardCnt,
  output ctrl_strobe_t     strobe,
  output logic             reqErr
);

  localparam int SUM_W = CNT_W + 2;
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_CELLS);

  logic             running;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] lastTick, bMag, bDead, bDemag, bGuard;
  logic [SUM_W-1:0] sumNeed;
  logic             srcOk, snkOk, timeOk, reqOk, startNow, stopNow;
  phase_e           phaseNow;

  assign sumNeed = SUM_W'(magCnt) + SUM_W'(deadCnt) + SUM_W'(demagCnt) + SUM_W'(guardCnt);
  assign srcOk   = (srcIdx != '0) && (srcIdx <= MAX_IDX);
  assign snkOk   = (snkIdx != '0) && (snkIdx <= MAX_IDX);
  assign timeOk  = (magCnt != '0) && (deadCnt != '0) && (demagCnt != '0) &&
                   (guardCnt != '0) && (sumNeed <= SUM_W'(periodCnt));
  assign reqOk   = srcOk && snkOk && (srcIdx != snkIdx) && timeOk;

  assign startNow = !running && enable && !abort && reqOk;
  assign stopNow  = running && (!enable || abort);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      tick     <= '0;
      lastTick <= '0;
      bMag     <= '0;
      bDead    <= '0;
      bDemag   <= '0;
      bGuard   <= '0;
      reqErr   <= 1'b0;
    end else begin
      reqErr <= !running && enable && !abort && !reqOk;
      if (stopNow) begin
        running <= 1'b0;
        tick    <= '0;
      end else if (startNow) begin
        running  <= 1'b1;
        tick     <= '0;
        // phase boundaries precomputed once per start
        lastTick <= periodCnt - CNT_W'(1);
        bMag     <= magCnt;
        bDead    <= magCnt + deadCnt;
        bDemag   <= magCnt + deadCnt + demagCnt;
        bGuard   <= periodCnt - guardCnt;
      end else if (running) begin
        tick <= (tick == lastTick) ? '0 : tick + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (!running)           phaseNow = PH_IDLE;
    else if (tick < bMag)   phaseNow = PH_MAG;
    else if (tick < bDead)  phaseNow = PH_DEAD;
    else if (tick < bDemag) phaseNow = PH_DEMAG;
    else if (tick < bGuard) phaseNow = PH_NONCOND;
    else                    phaseNow = PH_GUARD;
  end

  assign strobe.latchReq = startNow;
  assign strobe.phase    = phaseNow;

endmodule

// File: rtl/bal_datapath.sv
module bal_datapath
  import bal_switch_seq_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int IDX_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [IDX_W-1:0]   snkIdx,
  input  logic               selWrEn,
  input  logic [1:0]         selWrAddr,
  input  logic [ENTRY_W-1:0] selWrData,
  output logic [NUM_CELLS:0] muxEn,
  output logic [3:0]         selEn
);

  logic [IDX_W-1:0]   srcL, snkL, activeIdx;
  logic [ENTRY_W-1:0] legTable [TBL_N];
  logic [ENTRY_W-1:0] entry;
  logic               srcSide, snkSide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcL <= '0;
      snkL <= '0;
      for (int e = 0; e < TBL_N; e++) legTable[e] <= ENTRY_RESET;
    end else begin
      if (strobe.latchReq) begin
        srcL <= srcIdx;
        snkL <= snkIdx;
      end
      if (selWrEn) legTable[selWrAddr] <= selWrData;
    end
  end

  // parity address: {source even, sink even}
  assign entry     = legTable[{~srcL[0], ~snkL[0]}];
  assign srcSide   = (strobe.phase == PH_MAG);
  assign snkSide   = (strobe.phase == PH_DEMAG) || (strobe.phase == PH_NONCOND);
  assign activeIdx = srcSide ? srcL : snkL;

  // cell c sits between pairs c and c+1 -> bits c-1 and c
  for (genvar i = 0; i <= NUM_CELLS; i++) begin : g_pair
    assign muxEn[i] = (srcSide || snkSide) &&
                      ((activeIdx == IDX_W'(i)) || (activeIdx == IDX_W'(i + 1)));
  end

  always_comb begin
    selEn = '0;
    if (srcSide)      selEn[entry[LEG_W-1:0]]       = 1'b1;
    else if (snkSide) selEn[entry[ENTRY_W-1:LEG_W]] = 1'b1;
  end

endmodule

// File: rtl/bal_switch_seq.sv
module bal_switch_seq
  import bal_switch_seq_pkg::*;
#(
  parameter  int NUM_CELLS = 5,
  parameter  int CNT_W     = 16,
  localparam int IDX_W     = $clog2(NUM_CELLS + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               abort,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [IDX_W-1:0]   snkIdx,
  input  logic [CNT_W-1:0]   periodCnt,
  input  logic [CNT_W-1:0]   magCnt,
  input  logic [CNT_W-1:0]   deadCnt,
  input  logic [CNT_W-1:0]   demagCnt,
  input  logic [CNT_W-1:0]   guardCnt,
  input  logic               selWrEn,
  input  logic [1:0]         selWrAddr,
  input  logic [3:0]         selWrData,
  output logic [NUM_CELLS:0] muxEn,
  output logic [3:0]         selEn,
  output logic [2:0]         phase,
  output logic               reqErr
);

  ctrl_strobe_t strobe;

  bal_ctrl #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .abort(abort),
    .srcIdx(srcIdx), .snkIdx(snkIdx), .periodCnt(periodCnt),
    .magCnt(magCnt), .deadCnt(deadCnt), .demagCnt(demagCnt),
    .guardCnt(guardCnt), .strobe(strobe), .reqErr(reqErr)
  );

  bal_datapath #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcIdx(srcIdx), .snkIdx(snkIdx),
    .selWrEn(selWrEn), .selWrAddr(selWrAddr), .selWrData(selWrData),
    .muxEn(muxEn), .selEn(selEn)
  );

  assign phase = strobe.phase;

endmodule

// File: rtl/bal_switch_seq_chk.sv
module bal_switch_seq_chk #(
  parameter int NUM_CELLS = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               abort,
  input logic [NUM_CELLS:0] muxEn,
  input logic [3:0]         selEn,
  input logic [2:0]         phase,
  input logic               reqErr
);

  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selEn));

  a_r10_pair_count: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(muxEn) == 0) || ($countones(muxEn) == 2));

  a_r3_dead_follows_mag: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd1) |=> (phase == 3'd1 || phase == 3'd2 || phase == 3'd0));

  a_r3_dead_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2) |-> (muxEn == '0 && selEn == '0));

  a_r5_guard_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd5) |-> (muxEn == '0 && selEn == '0));

  a_r5_guard_then_mag: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd5) |=> (phase == 3'd5 || phase == 3'd1 || phase == 3'd0));

  a_r9_stop_next: assert property (@(posedge clk) disable iff (!rstN)
    (abort || !enable) |=> (phase == 3'd0 && muxEn == '0 && selEn == '0));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (muxEn == '0 && selEn == '0));

endmodule

bind bal_switch_seq bal_switch_seq_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .abort(abort),
  .muxEn(muxEn), .selEn(selEn), .phase(phase), .reqErr(reqErr)
);

// File: tb/test_bal_switch_seq.sv
module test_bal_switch_seq;

  localparam int N = 5;
  localparam int W = 16;

  logic clk = 0, rstN = 0, enable = 0, abort = 0;
  logic [2:0] srcIdx = 0, snkIdx = 0;
  logic [W-1:0] periodCnt = 0, magCnt = 0, deadCnt = 0, demagCnt = 0, guardCnt = 0;
  logic selWrEn = 0;
  logic [1:0] selWrAddr = 0;
  logic [3:0] selWrData = 0;
  logic [N:0] muxEn;
  logic [3:0] selEn;
  logic [2:0] phase;
  logic reqErr;

  int compared = 0, mismatched = 0;
  int P, M, D, X, G;
  int tMag[4], tDem[4];
  logic [N:0] eMux;
  logic [3:0] eSel;
  int ePh;

  always #2.5 clk = ~clk;

  bal_switch_seq #(.NUM_CELLS(N), .CNT_W(W)) i_bal_switch_seq (.*);

  task automatic check(string tag, logic [N:0] xm, logic [3:0] xs, int xp, logic xe);
    compared++;
    if (muxEn !== xm || selEn !== xs || int'(phase) != xp || reqErr !== xe) begin
      mismatched++;
      $display("FAIL %s actual mux=%b sel=%b ph=%0d err=%b expected mux=%b sel=%b ph=%0d err=%b",
               tag, muxEn, selEn, phase, reqErr, xm, xs, xp, xe);
    end
  endtask

  task automatic setTiming(int p, int m, int d, int x, int g);
    P = p; M = m; D = d; X = x; G = g;
    periodCnt = W'(p); magCnt = W'(m); deadCnt = W'(d); demagCnt = W'(x); guardCnt = W'(g);
  endtask

  task automatic calc(int s, int k, int t);
    int a;
    a = ((s % 2 == 0) ? 2 : 0) + ((k % 2 == 0) ? 1 : 0);
    eMux = '0; eSel = '0;
    if (t < M) begin
      ePh = 1; eMux[s-1] = 1'b1; eMux[s] = 1'b1; eSel[tMag[a]] = 1'b1;
    end else if (t < M + D) begin
      ePh = 2;
    end else if (t < P - G) begin
      ePh = (t < M + D + X) ? 3 : 4;
      eMux[k-1] = 1'b1; eMux[k] = 1'b1; eSel[tDem[a]] = 1'b1;
    end else begin
      ePh = 5;
    end
  endtask

  function automatic string phTag(int p);
    case (p)
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runValid(int s, int k, int cyc, string pre);
    @(negedge clk);
    srcIdx = 3'(s); snkIdx = 3'(k); enable = 1;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      calc(s, k, c % P);
      check($sformatf("%s %s src=%0d snk=%0d t=%0d", pre, phTag(ePh), s, k, c % P),
            eMux, eSel, ePh, 1'b0);
    end
    enable = 0;
    @(negedge clk);
    check("R9 enable low -> idle", '0, '0, 0, 1'b0);
  endtask

  task automatic runInvalid(string tag);
    @(negedge clk);
    enable = 1;
    @(negedge clk);
    check(tag, '0, '0, 0, 1'b1);
    enable = 0;
    @(negedge clk);
  endtask

  task automatic sweep(string pre);
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 8; k++) begin
        if (s >= 1 && s <= N && k >= 1 && k <= N && s != k)
          runValid(s, k, 2 * P, pre);
        else begin
          srcIdx = 3'(s); snkIdx = 3'(k);
          runInvalid($sformatf("R7 src=%0d snk=%0d", s, k));
        end
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++) begin tMag[a] = 0; tDem[a] = 3; end
    setTiming(20, 6, 2, 3, 2);
    repeat (3) @(negedge clk);
    check("R1 reset", '0, '0, 0, 1'b0);
    enable = 1; srcIdx = 1; snkIdx = 3;
    @(negedge clk);
    check("R1 reset holds with enable", '0, '0, 0, 1'b0);
    enable = 0;
    rstN = 1;
    @(negedge clk);

    // R2..R5, R7 with reset table (R6 reset value)
    sweep("R6rst");

    // R6: program distinct legs per parity entry
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      tMag[a] = a; tDem[a] = (a + 2) % 4;
      selWrEn = 1; selWrAddr = 2'(a); selWrData = 4'((tDem[a] << 2) | tMag[a]);
    end
    @(negedge clk);
    selWrEn = 0;
    // R8 exact fit: non-conduction empty
    setTiming(12, 4, 1, 5, 2);
    sweep("R6prog R8fit");

    // R8: overshoot by one, and a zero count
    srcIdx = 1; snkIdx = 2;
    setTiming(10, 4, 1, 3, 3);
    runInvalid("R8 sum over period");
    setTiming(10, 0, 1, 3, 3);
    runInvalid("R8 zero magnetise");
    setTiming(10, 3, 1, 3, 3);
    runValid(1, 2, 10, "R8 legal");

    // R9: abort mid-period
    setTiming(20, 6, 2, 3, 2);
    @(negedge clk);
    srcIdx = 2; snkIdx = 5; enable = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      calc(2, 5, c);
      check("R9 before abort R2", eMux, eSel, ePh, 1'b0);
    end
    abort = 1;
    @(negedge clk);
    check("R9 abort -> idle", '0, '0, 0, 1'b0);
    enable = 0; abort = 0;
    @(negedge clk);

    // R11: inputs changed mid-run are ignored
    @(negedge clk);
    srcIdx = 4; snkIdx = 1; enable = 1;
    for (int c = 0; c < 2 * P; c++) begin
      @(negedge clk);
      calc(4, 1, c % P);
      check($sformatf("R11 latched t=%0d", c % P), eMux, eSel, ePh, 1'b0);
      if (c == 1) begin
        srcIdx = 3; snkIdx = 0; periodCnt = 7; magCnt = 1;
      end
    end
    enable = 0;
    @(negedge clk);
    check("R9 final idle", '0, '0, 0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule